// File: doc/BRIEF.md
# Queue-Driven Interrupt Status Unit

This block keeps the interrupt state of a packet controller. It holds an 8-bit status register, an 8-bit enable mask and a single interrupt request line. Event logic elsewhere in the controller sets status bits with one-cycle pulses. Two bits also follow the state of two queues that live outside this block. The first is the transmit queue, whose bit goes on while that queue is empty. The second is the transmit-completion queue, whose bit goes on while that queue still holds entries. The host reads status and mask back directly. It writes one byte at a time, either into the mask or as an acknowledge that clears status bits.

Only five status bits can be cleared by acknowledge. The other three (received packet, allocation done, PHY event) stay set until reset. When an acknowledge byte carries the transmit-complete bit, the block pulses a pop strobe towards the completion queue. The pop is taken into account before the queue-driven bits are evaluated again. The request output is registered, so it follows the status and mask one clock later.

The write port is a plain strobe with no back-pressure: every write with `wr_en` high takes effect at the next rising edge. The pop strobe is a single-cycle request, and the completion queue must accept it.

Top module: `isu_top`

## Requirements
- R1: During and right after reset, status reads 0x04, mask reads 0x00 and `irq` is low.
- R2: A bit set in `ev_set` during a cycle is set in `stat_q` after the next rising edge.
- R3: An acknowledge write (`wr_sel`=0) clears only those written bits that are inside 0xD6 (bits 7, 6, 4, 2 and 1). Bits 5, 3 and 0 are never cleared by it, and the mask does not change.
- R4: Bit 2 (transmit idle) is set after every rising edge at which `txq_len` was zero.
- R5: Bit 1 (transmit done) is set after every rising edge at which `done_len` minus the pop of that cycle was nonzero.
- R6: `done_pop` is high exactly in a cycle that has an acknowledge write with bit 1 set while `done_len` is nonzero.
- R7: A mask write (`wr_sel`=1) replaces the whole mask with `wr_data` at the next edge and leaves the status unchanged.
- R8: `irq` equals the OR of (`stat_q` AND `mask_q`) as it stood one clock earlier.
- R9: When an event pulse and an acknowledge hit the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 8 | One-cycle set pulses, one per status bit |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel | input | 1 | 0 = acknowledge, 1 = mask write |
| wr_data | input | 8 | Host write byte |
| txq_len | input | QW | Current transmit queue length |
| done_len | input | QW | Current completion queue length |
| stat_q | output | 8 | Status register |
| mask_q | output | 8 | Mask register |
| irq | output | 1 | Registered interrupt request |
| done_pop | output | 1 | Pop strobe to the completion queue |

## Verification
Every one of the 256 acknowledge bytes is applied to an all-ones status. This separates the clearable bits from the sticky ones. Each event bit is pulsed on its own, which shows that bits are not crossed. All pairs of queue lengths from 0 to the queue depth are crossed with a transmit-done acknowledge. This separates a correct pop-then-evaluate order from one that evaluates first, and it shows that no pop is issued on an empty queue. All 256 mask bytes are applied to a known status to check the one-clock lag of `irq`. A combined event-plus-acknowledge write checks that the event wins.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned BIT_RXPKT   = 0;
  localparam int unsigned BIT_TXDONE  = 1;
  localparam int unsigned BIT_TXIDLE  = 2;
  localparam int unsigned BIT_ALLOC   = 3;
  localparam int unsigned BIT_RXOVF   = 4;
  localparam int unsigned BIT_PHYEVT  = 5;
  localparam int unsigned BIT_EARLYRX = 6;
  localparam int unsigned BIT_MGMT    = 7;

  // bits an acknowledge write may clear
  localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [STAT_W-1:0] RESET_STAT    = 8'h04;

  typedef enum logic {
    SEL_ACK  = 1'b0,
    SEL_MASK = 1'b1
  } wsel_e;
endpackage

// File: rtl/isu_ack_decode.sv
module isu_ack_decode
  import isu_pkg::*;
#(
  parameter int unsigned QW = 3
) (
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [QW-1:0]     done_len,
  output logic [STAT_W-1:0] clr_bits,
  output logic              mask_we,
  output logic              pop
);
  logic is_ack;

  always_comb begin
    is_ack   = wr_en && (wsel_e'(wr_sel) == SEL_ACK);
    mask_we  = wr_en && (wsel_e'(wr_sel) == SEL_MASK);
    clr_bits = is_ack ? (wr_data & ACK_CLEARABLE) : '0;
    pop      = is_ack && wr_data[BIT_TXDONE] && (done_len != '0);
  end
endmodule

// File: rtl/isu_level_force.sv
module isu_level_force
  import isu_pkg::*;
#(
  parameter int unsigned QW = 3
) (
  input  logic [QW-1:0]     txq_len,
  input  logic [QW-1:0]     done_len,
  input  logic              pop,
  output logic [STAT_W-1:0] force_bits
);
  logic [QW-1:0] done_after;

  always_comb begin
    done_after = done_len - QW'(pop);
    force_bits = '0;
    force_bits[BIT_TXIDLE] = (txq_len == '0);
    force_bits[BIT_TXDONE] = (done_after != '0);
  end
endmodule

// File: rtl/isu_status_reg.sv
module isu_status_reg
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_bits,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] force_bits,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_d,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq_q
);
  localparam logic [STAT_W-1:0] STICKY = ~ACK_CLEARABLE;

  logic [STAT_W-1:0] stat_d;

  always_comb stat_d = (stat_q & ~clr_bits) | set_bits | force_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= RESET_STAT;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= mask_d;
      irq_q  <= |(stat_q & mask_q);
    end
  end

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q) & STICKY) == ($past(stat_q) & STICKY)));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & mask_q)) |=> irq_q);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & mask_q)) |=> !irq_q);
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned QW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_set,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [QW-1:0]     txq_len,
  input  logic [QW-1:0]     done_len,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq,
  output logic              done_pop
);
  logic [STAT_W-1:0] clr_bits;
  logic [STAT_W-1:0] force_bits;
  logic              mask_we;

  isu_ack_decode #(.QW(QW)) u_ack (
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .done_len (done_len),
    .clr_bits (clr_bits),
    .mask_we  (mask_we),
    .pop      (done_pop)
  );

  isu_level_force #(.QW(QW)) u_force (
    .txq_len    (txq_len),
    .done_len   (done_len),
    .pop        (done_pop),
    .force_bits (force_bits)
  );

  isu_status_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_bits   (ev_set),
    .clr_bits   (clr_bits),
    .force_bits (force_bits),
    .mask_we    (mask_we),
    .mask_d     (wr_data),
    .stat_q     (stat_q),
    .mask_q     (mask_q),
    .irq_q      (irq)
  );

  // R2
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((stat_q & $past(ev_set)) == $past(ev_set)));

  // R4
  txidle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_len == '0) |=> stat_q[BIT_TXIDLE]);

  // R5
  txdone_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_len > QW'(1)) || (done_len == QW'(1) && !done_pop)) |=> stat_q[BIT_TXDONE]);

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_len == '0) |-> !done_pop);
endmodule

// File: tb/tb_isu_top.sv
module tb_isu_top;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned QW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    ev_set = '0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [QW-1:0] txq_len = QW'(1);
  logic [QW-1:0] done_len = '0;
  logic [7:0]    stat_q;
  logic [7:0]    mask_q;
  logic          irq;
  logic          done_pop;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] es = 8'h04;
  logic [7:0] em = 8'h00;
  logic       ei = 1'b0;

  always #5 clk = ~clk;

  isu_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .txq_len(txq_len), .done_len(done_len), .stat_q(stat_q),
    .mask_q(mask_q), .irq(irq), .done_pop(done_pop)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock with the given stimulus; model computed from the requirements
  task automatic cyc(input string tag, input logic [7:0] ev, input logic we,
                     input logic sel, input logic [7:0] d,
                     input int tl, input int dl);
    logic [7:0] clr;
    logic       pop_e;
    int         dla;
    ev_set = ev; wr_en = we; wr_sel = sel; wr_data = d;
    txq_len = QW'(tl); done_len = QW'(dl);
    clr   = (we && !sel) ? (d & 8'hD6) : 8'h00;
    pop_e = we && !sel && d[1] && (dl != 0);
    dla   = dl - (pop_e ? 1 : 0);
    #1;
    check("R6 pop", done_pop, pop_e);
    ei = |(es & em);
    es = (es & ~clr) | ev | ((tl == 0) ? 8'h04 : 8'h00) | ((dla != 0) ? 8'h02 : 8'h00);
    if (we && sel) em = d;
    @(posedge clk);
    #1;
    ev_set = '0; wr_en = 1'b0;
    check(tag, stat_q, es);
    check("R7 mask", mask_q, em);
    check("R8 irq", irq, ei);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    check("R1 stat", stat_q, 8'h04);
    check("R1 mask", mask_q, 8'h00);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    check("R1 stat after release", stat_q, 8'h04);

    // clear clearable bits, then single event pulses (R2)
    cyc("R3 clear all", 8'h00, 1, 0, 8'hFF, 1, 0);
    for (int i = 0; i < 8; i++) begin
      cyc("R2 event", 8'(1 << i), 0, 0, 8'h00, 1, 0);
      cyc("R3 ack after event", 8'h00, 1, 0, 8'hFF, 1, 0);
    end

    // acknowledge sweep over all bytes from all-ones status (R3)
    for (int v = 0; v < 256; v++) begin
      cyc("R2 set all", 8'hFF, 0, 0, 8'h00, 1, 0);
      cyc("R3 ack sweep", 8'h00, 1, 0, 8'(v), 1, 0);
    end

    // queue levels crossed with transmit-done acknowledge (R4, R5, R6)
    for (int tl = 0; tl <= DEPTH; tl++) begin
      for (int dl = 0; dl <= DEPTH; dl++) begin
        cyc("R4 R5 ack levels", 8'h00, 1, 0, 8'h06, tl, dl);
        cyc("R5 ack no txdone", 8'h00, 1, 0, 8'h04, tl, dl);
        cyc("R4 R5 idle", 8'h00, 0, 0, 8'h00, tl, dl);
      end
    end
    // mask write must not act as acknowledge (R6, R7)
    cyc("R7 mask no pop", 8'h00, 1, 1, 8'h02, 1, 2);

    // mask sweep with irq lag (R7, R8)
    cyc("R2 set all", 8'hFF, 0, 0, 8'h00, 1, 0);
    cyc("R3 partial clear", 8'h00, 1, 0, 8'h52, 1, 0);
    for (int v = 0; v < 256; v++) begin
      cyc("R7 mask sweep", 8'h00, 1, 1, 8'(v), 1, 0);
      cyc("R8 irq follow", 8'h00, 0, 0, 8'h00, 1, 0);
    end

    // event beats acknowledge on the same bit (R9)
    cyc("R3 clear", 8'h00, 1, 0, 8'hFF, 1, 0);
    cyc("R9 event wins", 8'hD6, 1, 0, 8'hFF, 1, 0);
    check("R9 all clearable set", stat_q & 8'hD6, 8'hD6);
    cyc("R9 event wins txdone", 8'h02, 1, 0, 8'h02, 1, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule